// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 32-bit RISC core with fixed 4-byte instructions fetches next. For each control-flow operation it takes the current PC, a 3-bit kind code, the value of the register under test, a register-held target, and the raw 16-bit and 26-bit offset fields from the instruction word. The offset fields are sign-extended inside the block. It returns the next PC, a taken flag, and a link-write request. The link write always names register 31 and carries PC+4.

Every PC-relative target is measured from PC+4, not from the PC itself. Both conditional forms compare one register against zero. The taken flag is set for every jump and for every branch whose condition holds, so a pipeline can use it to flush the younger instructions behind the branch.

Requests arrive on a valid/ready input and leave through one output register on a valid/ready output. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle because `out_ready` is high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken.

Top module: `npc_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, `out_valid` is 0.
- R2: Kind 0 (sequential) and kind 7 (reserved) give a next PC of PC+4, taken 0 and no link write.
- R3: Kind 1 (branch if zero) is taken when the tested register is zero. The target is then PC+4 plus the sign-extended 16-bit offset. Otherwise the next PC is PC+4 and taken is 0.
- R4: Kind 2 (branch if not zero) is taken when the tested register is non-zero. The target is PC+4 plus the sign-extended 16-bit offset. Otherwise the next PC is PC+4 and taken is 0.
- R5: Kind 3 (relative jump) sets the next PC to PC+4 plus the sign-extended 26-bit offset.
- R6: Kind 4 (register jump) sets the next PC to the register target value.
- R7: Kind 5 (relative jump with link) and kind 6 (register jump with link) set the link-write request. The destination is register 31 and the data is PC+4 of the request itself. The jump target is computed as for kind 3 or kind 4, from the target value supplied with the request, even when that value is the old contents of register 31. `out_link_data` carries PC+4 for every kind.
- R8: No kind other than 5 or 6 raises the link-write request.
- R9: While `out_valid` is 1 and `out_ready` is 0, the outputs stay unchanged and `in_ready` is 0.
- R10: A request accepted in one cycle appears on the outputs, with `out_valid` set, in the next cycle.
- R11: All PC arithmetic wraps modulo 2^32.
- R12: The taken flag is 1 for kinds 3, 4, 5 and 6, whatever the register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_pc | input | 32 | PC of the control-flow instruction |
| in_kind | input | 3 | Control-flow kind code (0..7, see R2-R7) |
| in_src | input | 32 | Value of the register tested against zero |
| in_tgt | input | 32 | Register target for kinds 4 and 6 |
| in_off16 | input | 16 | Raw 16-bit branch offset field |
| in_off26 | input | 26 | Raw 26-bit jump offset field |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_next_pc | output | 32 | Next fetch address |
| out_taken | output | 1 | Control flow leaves the sequential path |
| out_link_we | output | 1 | Link-register write request |
| out_link_addr | output | 5 | Link destination register (31) |
| out_link_data | output | 32 | PC+4 of the request |

## Verification
The bench builds the block with its defaults: a 32-bit address width, 16- and 26-bit offset fields, 4-byte instructions and register 31 as the link target. At these values the sign bit of each offset field can be driven directly, which exercises backward branches and backward jumps. Directed PCs near 0xFFFFFFFC make PC+4 and the target adds cross the 2^32 boundary. Random `out_ready` patterns, mixed with a directed stall, hold the output register full under back-pressure while different requests are waiting at the input.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CF_SEQ       = 3'd0,
    CF_BEQZ      = 3'd1,
    CF_BNEZ      = 3'd2,
    CF_JREL      = 3'd3,
    CF_JREG      = 3'd4,
    CF_JREL_LINK = 3'd5,
    CF_JREG_LINK = 3'd6,
    CF_RSVD      = 3'd7
  } cf_kind_e;
endpackage

// File: rtl/npc_adders.sv
module npc_adders #(
  parameter int XLEN        = 32,
  parameter int BR_OFF_W    = 16,
  parameter int JMP_OFF_W   = 26,
  parameter int INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0]      pc,
  input  logic [BR_OFF_W-1:0]  off_br,
  input  logic [JMP_OFF_W-1:0] off_jmp,
  output logic [XLEN-1:0]      seq_pc,
  output logic [XLEN-1:0]      br_target,
  output logic [XLEN-1:0]      jmp_target
);
  localparam int BR_EXT  = XLEN - BR_OFF_W;
  localparam int JMP_EXT = XLEN - JMP_OFF_W;

  logic [XLEN-1:0] br_sext;
  logic [XLEN-1:0] jmp_sext;

  // Offset fields are sign-extended to the full address width.
  assign br_sext    = {{BR_EXT{off_br[BR_OFF_W-1]}}, off_br};
  assign jmp_sext   = {{JMP_EXT{off_jmp[JMP_OFF_W-1]}}, off_jmp};
  assign seq_pc     = pc + XLEN'(INSTR_BYTES);
  // Both relative targets are measured from the incremented PC.
  assign br_target  = seq_pc + br_sext;
  assign jmp_target = seq_pc + jmp_sext;
endmodule

// File: rtl/npc_decode.sv
module npc_decode #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind,
  input  logic [XLEN-1:0] src,
  output logic            take_br,
  output logic            take_rel,
  output logic            take_reg,
  output logic            link
);
  import npc_pkg::*;

  logic src_zero;
  assign src_zero = (src == '0);

  always_comb begin
    take_br  = 1'b0;
    take_rel = 1'b0;
    take_reg = 1'b0;
    link     = 1'b0;
    unique case (cf_kind_e'(kind))
      CF_BEQZ:      take_br  = src_zero;
      CF_BNEZ:      take_br  = !src_zero;
      CF_JREL:      take_rel = 1'b1;
      CF_JREG:      take_reg = 1'b1;
      CF_JREL_LINK: begin take_rel = 1'b1; link = 1'b1; end
      CF_JREG_LINK: begin take_reg = 1'b1; link = 1'b1; end
      default:      ;
    endcase
  end
endmodule

// File: rtl/npc_select.sv
module npc_select #(
  parameter int XLEN = 32
) (
  input  logic            take_br,
  input  logic            take_rel,
  input  logic            take_reg,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_target,
  input  logic [XLEN-1:0] jmp_target,
  input  logic [XLEN-1:0] reg_target,
  output logic [XLEN-1:0] next_pc,
  output logic            taken
);
  always_comb begin
    next_pc = seq_pc;
    if (take_br)  next_pc = br_target;
    if (take_rel) next_pc = jmp_target;
    if (take_reg) next_pc = reg_target;
  end
  assign taken = take_br | take_rel | take_reg;
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int XLEN        = 32,
  parameter int BR_OFF_W    = 16,
  parameter int JMP_OFF_W   = 26,
  parameter int INSTR_BYTES = 4,
  parameter int REG_AW      = 5,
  parameter int LINK_REG    = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [XLEN-1:0]      in_pc,
  input  logic [2:0]           in_kind,
  input  logic [XLEN-1:0]      in_src,
  input  logic [XLEN-1:0]      in_tgt,
  input  logic [BR_OFF_W-1:0]  in_off16,
  input  logic [JMP_OFF_W-1:0] in_off26,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XLEN-1:0]      out_next_pc,
  output logic                 out_taken,
  output logic                 out_link_we,
  output logic [REG_AW-1:0]    out_link_addr,
  output logic [XLEN-1:0]      out_link_data
);
  logic [XLEN-1:0] seq_pc, br_target, jmp_target, nxt;
  logic            take_br, take_rel, take_reg, link, taken;
  logic            accept;

  npc_adders #(
    .XLEN(XLEN), .BR_OFF_W(BR_OFF_W), .JMP_OFF_W(JMP_OFF_W), .INSTR_BYTES(INSTR_BYTES)
  ) u_add (
    .pc(in_pc), .off_br(in_off16), .off_jmp(in_off26),
    .seq_pc(seq_pc), .br_target(br_target), .jmp_target(jmp_target)
  );

  npc_decode #(.XLEN(XLEN)) u_dec (
    .kind(in_kind), .src(in_src),
    .take_br(take_br), .take_rel(take_rel), .take_reg(take_reg), .link(link)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .take_br(take_br), .take_rel(take_rel), .take_reg(take_reg),
    .seq_pc(seq_pc), .br_target(br_target), .jmp_target(jmp_target),
    .reg_target(in_tgt), .next_pc(nxt), .taken(taken)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // The link data is the request's own PC+4, captured together with the
  // target, so a link jump through the link register uses its old value.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_next_pc   <= '0;
      out_taken     <= 1'b0;
      out_link_we   <= 1'b0;
      out_link_data <= '0;
    end else if (accept) begin
      out_next_pc   <= nxt;
      out_taken     <= taken;
      out_link_we   <= link;
      out_link_data <= seq_pc;
    end
  end

  assign out_link_addr = REG_AW'(LINK_REG);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN     = 32,
  parameter int REG_AW   = 5,
  parameter int LINK_REG = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_kind,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   out_next_pc,
  input logic              out_taken,
  input logic              out_link_we,
  input logic [REG_AW-1:0] out_link_addr,
  input logic [XLEN-1:0]   out_link_data
);
  logic is_jump, is_link;
  assign is_jump = (in_kind >= 3'd3) && (in_kind <= 3'd6);
  assign is_link = (in_kind == 3'd5) || (in_kind == 3'd6);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_taken)
      && $stable(out_link_we) && $stable(out_link_data)); // R9

  AST_LINK_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_link_addr == REG_AW'(LINK_REG)); // R7

  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == out_link_data); // R2

  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && is_jump |=> out_valid && out_taken); // R12

  AST_NO_STRAY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !is_link |=> !out_link_we); // R8

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW), .LINK_REG(LINK_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
  .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
  .out_taken(out_taken), .out_link_we(out_link_we), .out_link_addr(out_link_addr),
  .out_link_data(out_link_data)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0, in_src = '0, in_tgt = '0;
  logic [2:0]  in_kind = '0;
  logic [15:0] in_off16 = '0;
  logic [25:0] in_off26 = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [31:0] out_next_pc, out_link_data;
  logic        out_taken, out_link_we;
  logic [4:0]  out_link_addr;

  int checks = 0, failures = 0;
  string tag_override = "";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_kind(in_kind), .in_src(in_src), .in_tgt(in_tgt),
    .in_off16(in_off16), .in_off26(in_off26), .out_valid(out_valid),
    .out_ready(out_ready), .out_next_pc(out_next_pc), .out_taken(out_taken),
    .out_link_we(out_link_we), .out_link_addr(out_link_addr),
    .out_link_data(out_link_data)
  );

  // Expected result: {next_pc, taken, link_we, link_data}
  function automatic logic [65:0] model(input logic [2:0] k, input logic [31:0] pc,
      input logic [31:0] src, input logic [31:0] tgt, input logic [15:0] o16,
      input logic [25:0] o26);
    logic [31:0] inc, nx;
    logic tk, we;
    inc = pc + 32'd4;
    nx = inc; tk = 0; we = 0;
    case (k)
      3'd1: if (src == 0) begin tk = 1; nx = inc + {{16{o16[15]}}, o16}; end
      3'd2: if (src != 0) begin tk = 1; nx = inc + {{16{o16[15]}}, o16}; end
      3'd3: begin tk = 1; nx = inc + {{6{o26[25]}}, o26}; end
      3'd4: begin tk = 1; nx = tgt; end
      3'd5: begin tk = 1; we = 1; nx = inc + {{6{o26[25]}}, o26}; end
      3'd6: begin tk = 1; we = 1; nx = tgt; end
      default: ;
    endcase
    return {nx, tk, we, inc};
  endfunction

  function automatic string kind_tag(input logic [2:0] k);
    case (k)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5, 3'd6: return "R7";
      default: return "R2";
    endcase
  endfunction

  // Reference of the output register, built from the handshake rules
  logic        exp_valid = 0;
  logic [65:0] exp_res = '0;
  logic [2:0]  exp_kind = '0;
  always @(posedge clk) begin
    if (!rst_n) exp_valid <= 0;
    else if (in_valid && (!exp_valid || out_ready)) begin
      exp_valid <= 1;
      exp_res   <= model(in_kind, in_pc, in_src, in_tgt, in_off16, in_off26);
      exp_kind  <= in_kind;
    end else if (out_ready) exp_valid <= 0;
  end

  task automatic fail(input string req, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
    failures++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic check_outputs();
    string t;
    checks++;
    t = (tag_override != "") ? tag_override : kind_tag(exp_kind);
    if (out_valid !== exp_valid) begin
      fail("R10", "out_valid", 64'(out_valid), 64'(exp_valid));
    end else if (exp_valid) begin
      if (out_next_pc !== exp_res[65:34])
        fail(t, "next_pc", 64'(out_next_pc), 64'(exp_res[65:34]));
      else if (out_taken !== exp_res[33])
        fail((exp_kind >= 3 && exp_kind <= 6) ? "R12" : t, "taken",
             64'(out_taken), 64'(exp_res[33]));
      else if (out_link_we !== exp_res[32])
        fail(exp_res[32] ? "R7" : "R8", "link_we", 64'(out_link_we), 64'(exp_res[32]));
      else if (out_link_data !== exp_res[31:0])
        fail("R7", "link_data", 64'(out_link_data), 64'(exp_res[31:0]));
      else if (out_link_we && out_link_addr !== 5'd31)
        fail("R7", "link_addr", 64'(out_link_addr), 64'd31);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] k, input logic [31:0] pc,
      input logic [31:0] src, input logic [31:0] tgt, input logic [15:0] o16,
      input logic [25:0] o26, input logic rdy);
    @(negedge clk);
    check_outputs();
    in_valid = v; in_kind = k; in_pc = pc; in_src = src; in_tgt = tgt;
    in_off16 = o16; in_off26 = o26; out_ready = rdy;
    #1;
    checks++;
    if (in_ready !== (!exp_valid || rdy))
      fail("R9", "in_ready", 64'(in_ready), 64'(!exp_valid || rdy));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1: held in reset
    if (out_valid !== 1'b0) fail("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    checks++; // R1: first cycle after reset
    if (out_valid !== 1'b0) fail("R1", "out_valid after reset", 64'(out_valid), 64'd0);

    // R3 / R4: zero and non-zero tested values, forward and backward offsets
    step(1, 3'd1, 32'h0000_1000, 32'h0, 0, 16'h0010, 0, 1);
    step(1, 3'd1, 32'h0000_1000, 32'h1, 0, 16'h0010, 0, 1);
    step(1, 3'd2, 32'h0000_2000, 32'h8000_0000, 0, 16'hFFF0, 0, 1);
    step(1, 3'd2, 32'h0000_2000, 32'h0, 0, 16'hFFF0, 0, 1);
    // R5 / R6: relative jump backwards, register jump
    step(1, 3'd3, 32'h0040_0000, 0, 0, 0, 26'h3FF_FFF8, 1);
    step(1, 3'd4, 32'h0040_0000, 0, 32'hDEAD_BEE0, 0, 0, 1);
    // R7: link forms; the register target is the old link value
    step(1, 3'd5, 32'h0000_3000, 0, 0, 0, 26'h000_0100, 1);
    step(1, 3'd6, 32'h0000_3004, 0, 32'h0000_3008, 0, 0, 1);
    // R2 / R8: sequential and reserved kinds
    step(1, 3'd0, 32'h0000_5000, 0, 32'h1234_5678, 16'h7FFF, 26'h1FF_FFFF, 1);
    step(1, 3'd7, 32'h0000_5004, 0, 32'h1234_5678, 16'h7FFF, 26'h1FF_FFFF, 1);
    // R11: wraparound at the top of the address space
    tag_override = "R11";
    step(1, 3'd0, 32'hFFFF_FFFC, 0, 0, 0, 0, 1);
    step(1, 3'd1, 32'hFFFF_FFF8, 0, 0, 16'h0008, 0, 1);
    step(1, 3'd5, 32'hFFFF_FFFC, 0, 0, 0, 26'h000_0004, 1);
    step(1, 3'd3, 32'h0000_0000, 0, 0, 0, 26'h3FF_FFF0, 1);
    // R9: stall with a different request waiting at the input
    tag_override = "R9";
    step(1, 3'd4, 32'h0000_6000, 0, 32'hAAAA_0000, 0, 0, 0);
    step(1, 3'd6, 32'h0000_7000, 0, 32'h5555_0000, 0, 0, 0);
    step(1, 3'd6, 32'h0000_7000, 0, 32'h5555_0000, 0, 0, 0);
    step(1, 3'd6, 32'h0000_7000, 0, 32'h5555_0000, 0, 0, 1);
    step(0, 3'd0, 0, 0, 0, 0, 0, 1);
    step(0, 3'd0, 0, 0, 0, 0, 0, 1);
    tag_override = "";

    // Random mix: kinds, zero-biased tested values, random back-pressure
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] s;
      s = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      step(($urandom % 4) != 0, 3'($urandom), $urandom, s, $urandom,
           16'($urandom), 26'($urandom), ($urandom % 3) != 0);
    end
    step(0, 3'd0, 0, 0, 0, 0, 0, 1);
    step(0, 3'd0, 0, 0, 0, 0, 0, 1);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule